// File: doc/BRIEF.md
# Cyclic Receive-Pattern Predictor

This block sits beside a receive path and watches the identifier of each posted receive, one per valid-qualified request. It learns a repeating sequence of identifiers and then announces, ahead of each request, which identifier it expects next. A later stage can use that guess to stage the matching message close to its consumer before the receive is posted. After each request in prediction mode, a one-cycle pulse reports whether the guess was right (hit) or wrong (miss).

Operation starts in an initialization mode. Every arriving identifier opens a candidate cycle, and a bounded set of candidates is followed at the same time. The first candidate whose head recurs after enough requests fixes the cycle, and the block moves to prediction. In prediction mode the stored cycle is replayed entry by entry, wrapping at its end. A miss throws the cycle away. The block then forms a new cycle with the missing identifier as head, recording requests until that head shows up again. All cycle contents live in one shared ring of identifier registers. Candidates, the forming cycle and the replayed cycle are only start positions and lengths into that ring.

Top module: `rcp_cycle_predictor`

## Requirements
- R1: While `rst` is high on a clock edge, the registered outputs `pred_valid`, `hit` and `miss` are 0 after that edge, and the block is in initialization mode with no candidates.
- R2: In initialization mode, a candidate whose head identifier arrives again after L requests (head included, the recurring request excluded), with L at least MIN_LEN (default 6), closes the cycle formed by those L requests. From the edge of the closing request, `pred_valid` is 1 and `pred_id` is the entry after the head. The closing request raises neither `hit` nor `miss`.
- R3: In initialization mode, a head that recurs after fewer than MIN_LEN requests does not end initialization; `pred_valid` stays 0 and the candidate restarts from the recurring request.
- R4: At most NUM_CAND (default 8) candidates exist. A request whose identifier is already a candidate head opens no new candidate. When every slot is busy, a new candidate replaces the one that has recorded the most requests (the lowest slot on a tie), so the replaced head can no longer close a cycle.
- R5: In prediction mode, each hit advances `pred_id` to the next cycle entry, and after the last entry `pred_id` returns to the head.
- R6: A request equal to `pred_id` while `pred_valid` is 1 gives `hit` = 1 and `miss` = 0 for exactly the cycle after its edge.
- R7: A request different from `pred_id` while `pred_valid` is 1 gives `miss` = 1 and `hit` = 0 for one cycle, drops `pred_valid` to 0, and makes that request the head of a new cycle.
- R8: While a cycle is forming after a miss, `pred_valid`, `hit` and `miss` stay 0. The cycle closes as soon as the head recurs, for any length from 1 to DEPTH (default 32) with no minimum, and prediction then resumes at the entry after the head.
- R9: A forming cycle that has recorded DEPTH requests without its head recurring is dropped when the next non-head request arrives, and that request becomes the new head.
- R10: A reset in the middle of a run returns the block to initialization, so the MIN_LEN rule applies again to the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A receive is posted this cycle |
| req_id | input | ID_W | Identifier of the posted receive |
| pred_valid | output | 1 | A prediction is available (prediction mode) |
| pred_id | output | ID_W | Predicted identifier of the next request |
| hit | output | 1 | One-cycle pulse: last request matched the prediction |
| miss | output | 1 | One-cycle pulse: last request did not match |

## Verification
The bench builds the block with its default parameters: 16-bit identifiers, a 32-entry ring, 8 candidate slots and a minimum first-cycle length of 6. With only 8 slots, 9 distinct identifiers are enough to force a replacement of the oldest candidate and to show that the evicted head can no longer close. A ring of 32 lets the bench form a cycle that fills the ring exactly, and then a cycle that overflows it by one request, in under a hundred requests. The minimum of 6 allows a length-2 recurrence to be shown ignored during initialization, while a length-1 or length-3 cycle formed after a miss is accepted.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

    typedef enum logic [1:0] {
        MODE_INIT = 2'd0,
        MODE_FORM = 2'd1,
        MODE_PRED = 2'd2
    } rcp_mode_e;

endpackage

// File: rtl/rcp_ring.sv
module rcp_ring #(
    parameter int ID_W  = 16,
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ID_W-1:0]  wr_id,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ID_W-1:0]  rd_id
);

    logic [ID_W-1:0] mem_q [DEPTH];
    logic [ID_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx] = wr_id;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_id = mem_q[rd_idx];

endmodule

// File: rtl/rcp_cand_bank.sv
module rcp_cand_bank #(
    parameter int ID_W     = 16,
    parameter int DEPTH    = 32,
    parameter int NUM_CAND = 8,
    parameter int MIN_LEN  = 6,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int LEN_W  = IDX_W + 1,
    localparam int CIDX_W = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             req_valid,
    input  logic [ID_W-1:0]  req_id,
    input  logic [IDX_W-1:0] wr_idx,
    output logic             close_o,
    output logic [IDX_W-1:0] close_start_o,
    output logic [LEN_W-1:0] close_len_o
);

    typedef struct packed {
        logic             valid;
        logic [ID_W-1:0]  head;
        logic [IDX_W-1:0] start;
        logic [LEN_W-1:0] len;
    } slot_t;

    localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);
    localparam logic [LEN_W-1:0] MIN_L   = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] ONE_L   = LEN_W'(1);

    slot_t slot_q [NUM_CAND];
    slot_t slot_d [NUM_CAND];

    logic [NUM_CAND-1:0] match_vec;
    logic                any_match;
    logic                have_free;
    logic [CIDX_W-1:0]   free_idx;
    logic [CIDX_W-1:0]   old_idx;
    logic [LEN_W-1:0]    old_len;
    logic [CIDX_W-1:0]   victim;

    // Slot scan: matching heads, first free slot, slot with most requests.
    always_comb begin
        any_match = 1'b0;
        have_free = 1'b0;
        free_idx  = '0;
        old_idx   = '0;
        old_len   = '0;
        for (int i = 0; i < NUM_CAND; i++) begin
            match_vec[i] = slot_q[i].valid && (slot_q[i].head == req_id);
            if (match_vec[i]) begin
                any_match = 1'b1;
            end
            if (!slot_q[i].valid && !have_free) begin
                have_free = 1'b1;
                free_idx  = CIDX_W'(i);
            end
            if (slot_q[i].valid && (slot_q[i].len > old_len)) begin
                old_len = slot_q[i].len;
                old_idx = CIDX_W'(i);
            end
        end
        victim = have_free ? free_idx : old_idx;
    end

    // Next-state of every slot and the close report.
    always_comb begin
        slot_d        = slot_q;
        close_o       = 1'b0;
        close_start_o = '0;
        close_len_o   = '0;
        if (active && req_valid) begin
            for (int i = 0; i < NUM_CAND; i++) begin
                if (slot_q[i].valid) begin
                    if (match_vec[i]) begin
                        if (slot_q[i].len >= MIN_L) begin
                            close_o       = 1'b1;
                            close_start_o = slot_q[i].start;
                            close_len_o   = slot_q[i].len;
                        end else begin
                            slot_d[i].start = wr_idx;
                            slot_d[i].len   = ONE_L;
                        end
                    end else if (slot_q[i].len == DEPTH_L) begin
                        slot_d[i].valid = 1'b0;
                    end else begin
                        slot_d[i].len = slot_q[i].len + ONE_L;
                    end
                end
            end
            if (!any_match) begin
                slot_d[victim] = '{valid: 1'b1, head: req_id,
                                   start: wr_idx, len: ONE_L};
            end
        end
        if (!active || close_o) begin
            for (int i = 0; i < NUM_CAND; i++) begin
                slot_d[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '{default: '0};
        end else begin
            slot_q <= slot_d;
        end
    end

endmodule

// File: rtl/rcp_cycle_predictor.sv
module rcp_cycle_predictor #(
    parameter int ID_W     = 16,
    parameter int DEPTH    = 32,
    parameter int NUM_CAND = 8,
    parameter int MIN_LEN  = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [ID_W-1:0] req_id,
    output logic            pred_valid,
    output logic [ID_W-1:0] pred_id,
    output logic            hit,
    output logic            miss
);

    import rcp_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);
    localparam int LEN_W = IDX_W + 1;
    localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);
    localparam logic [LEN_W-1:0] ONE_L   = LEN_W'(1);

    typedef struct packed {
        rcp_mode_e        mode;
        logic [IDX_W-1:0] wp;
        logic [IDX_W-1:0] cyc_start;
        logic [LEN_W-1:0] cyc_len;
        logic [IDX_W-1:0] ptr;
        logic [ID_W-1:0]  head;
        logic [IDX_W-1:0] fstart;
        logic [LEN_W-1:0] flen;
        logic             hit;
        logic             miss;
    } state_t;

    state_t st_q, st_d;

    logic             wr_en;
    logic [IDX_W-1:0] rd_idx;
    logic [ID_W-1:0]  rd_id;
    logic             cand_close;
    logic [IDX_W-1:0] cand_start;
    logic [LEN_W-1:0] cand_len;
    logic [IDX_W-1:0] wp_next;
    logic [LEN_W-1:0] ptr_inc;

    function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] a,
                                                  input logic [IDX_W-1:0] b);
        logic [LEN_W-1:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= DEPTH_L) begin
            s = s - DEPTH_L;
        end
        return s[IDX_W-1:0];
    endfunction

    function automatic logic [IDX_W-1:0] first_ptr(input logic [LEN_W-1:0] len);
        return (len == ONE_L) ? '0 : IDX_W'(1);
    endfunction

    rcp_ring #(
        .ID_W  (ID_W),
        .DEPTH (DEPTH)
    ) u_ring (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (st_q.wp),
        .wr_id  (req_id),
        .rd_idx (rd_idx),
        .rd_id  (rd_id)
    );

    rcp_cand_bank #(
        .ID_W     (ID_W),
        .DEPTH    (DEPTH),
        .NUM_CAND (NUM_CAND),
        .MIN_LEN  (MIN_LEN)
    ) u_cand (
        .clk           (clk),
        .rst           (rst),
        .active        (st_q.mode == MODE_INIT),
        .req_valid     (req_valid),
        .req_id        (req_id),
        .wr_idx        (st_q.wp),
        .close_o       (cand_close),
        .close_start_o (cand_start),
        .close_len_o   (cand_len)
    );

    assign rd_idx  = wrap_add(st_q.cyc_start, st_q.ptr);
    assign wp_next = wrap_add(st_q.wp, IDX_W'(1));
    assign ptr_inc = LEN_W'(st_q.ptr) + ONE_L;

    always_comb begin
        st_d      = st_q;
        st_d.hit  = 1'b0;
        st_d.miss = 1'b0;
        wr_en     = 1'b0;
        if (req_valid) begin
            unique case (st_q.mode)
                MODE_INIT: begin
                    wr_en   = 1'b1;
                    st_d.wp = wp_next;
                    if (cand_close) begin
                        st_d.mode      = MODE_PRED;
                        st_d.cyc_start = cand_start;
                        st_d.cyc_len   = cand_len;
                        st_d.ptr       = first_ptr(cand_len);
                    end
                end
                MODE_FORM: begin
                    wr_en   = 1'b1;
                    st_d.wp = wp_next;
                    if (req_id == st_q.head) begin
                        st_d.mode      = MODE_PRED;
                        st_d.cyc_start = st_q.fstart;
                        st_d.cyc_len   = st_q.flen;
                        st_d.ptr       = first_ptr(st_q.flen);
                    end else if (st_q.flen == DEPTH_L) begin
                        st_d.head   = req_id;
                        st_d.fstart = st_q.wp;
                        st_d.flen   = ONE_L;
                    end else begin
                        st_d.flen = st_q.flen + ONE_L;
                    end
                end
                MODE_PRED: begin
                    if (req_id == rd_id) begin
                        st_d.hit = 1'b1;
                        st_d.ptr = (ptr_inc == st_q.cyc_len) ? '0 : ptr_inc[IDX_W-1:0];
                    end else begin
                        st_d.miss   = 1'b1;
                        st_d.mode   = MODE_FORM;
                        st_d.head   = req_id;
                        st_d.fstart = st_q.wp;
                        st_d.flen   = ONE_L;
                        wr_en       = 1'b1;
                        st_d.wp     = wp_next;
                    end
                end
                default: begin
                    st_d.mode = MODE_INIT;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{mode: MODE_INIT, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pred_valid = (st_q.mode == MODE_PRED);
    assign pred_id    = rd_id;
    assign hit        = st_q.hit;
    assign miss       = st_q.miss;

endmodule

// File: rtl/rcp_checker.sv
module rcp_checker #(
    parameter int ID_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [ID_W-1:0] req_id,
    input logic            pred_valid,
    input logic [ID_W-1:0] pred_id,
    input logic            hit,
    input logic            miss
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!pred_valid && !hit && !miss));

    // R6
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(hit && miss));

    // R6
    hit_needs_pred_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && pred_valid && (req_id == pred_id)) |=> (hit && !miss));

    // R7
    miss_drops_pred_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && pred_valid && (req_id != pred_id)) |=> (miss && !pred_valid));

    // R8
    no_score_while_forming_chk: assert property (@(posedge clk) disable iff (rst)
        !pred_valid |=> (!hit && !miss));

    // R5
    idle_holds_pred_chk: assert property (@(posedge clk) disable iff (rst)
        (pred_valid && !req_valid) |=> (pred_valid && $stable(pred_id)));

endmodule

bind rcp_cycle_predictor rcp_checker #(.ID_W(ID_W)) u_rcp_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_id     (req_id),
    .pred_valid (pred_valid),
    .pred_id    (pred_id),
    .hit        (hit),
    .miss       (miss)
);

// File: tb/tb_rcp_cycle_predictor.sv
module tb_rcp_cycle_predictor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_id = '0;
    logic        pred_valid;
    logic [15:0] pred_id;
    logic        hit;
    logic        miss;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rcp_cycle_predictor dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_id     (req_id),
        .pred_valid (pred_valid),
        .pred_id    (pred_id),
        .hit        (hit),
        .miss       (miss)
    );

    // Drive one request; returns at the negedge after its edge.
    task automatic send(input logic [15:0] id);
        @(negedge clk);
        req_valid = 1'b1;
        req_id    = id;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_out(input string r, input bit epv, input bit ehit,
                              input bit emiss, input bit cpred, input logic [15:0] epred);
        bit bad;
        checks++;
        bad = (pred_valid !== epv) || (hit !== ehit) || (miss !== emiss) ||
              (cpred && (pred_id !== epred));
        if (bad) begin
            fails++;
            $display("FAIL %s: pv/hit/miss/pred = %0b/%0b/%0b/%h, expected %0b/%0b/%0b/%h",
                     r, pred_valid, hit, miss, pred_id, epv, ehit, emiss, epred);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // R1 and R2, R5, R6: preamble, first cycle of 6, replay with wrap
    task automatic t_init_close();
        logic [15:0] pre [9] = '{16'd1, 16'd3, 16'd5, 16'd4, 16'd6, 16'd7, 16'd8, 16'd9, 16'd10};
        logic [15:0] cyc [6] = '{16'd4, 16'd6, 16'd7, 16'd8, 16'd9, 16'd10};
        do_reset();
        expect_out("R1 reset state", 0, 0, 0, 0, '0);
        foreach (pre[i]) begin
            send(pre[i]);
            expect_out("R2 no prediction before close", 0, 0, 0, 0, '0);
        end
        send(16'd4);
        expect_out("R2 close at recurrence of head", 1, 0, 0, 1, 16'd6);
        for (int k = 1; k <= 6; k++) begin
            send(cyc[k % 6]);
            expect_out("R5 R6 replay hit", 1, 1, 0, 1, cyc[(k + 1) % 6]);
        end
    endtask

    // R7 and R8: miss, form a 3-entry cycle, then a 1-entry cycle
    task automatic t_miss_reform();
        send(16'h50);
        expect_out("R7 miss pulse", 0, 0, 1, 0, '0);
        send(16'h51);
        expect_out("R8 quiet while forming", 0, 0, 0, 0, '0);
        send(16'h52);
        expect_out("R8 quiet while forming", 0, 0, 0, 0, '0);
        send(16'h50);
        expect_out("R8 close length 3", 1, 0, 0, 1, 16'h51);
        send(16'h51);
        expect_out("R5 hit", 1, 1, 0, 1, 16'h52);
        send(16'h52);
        expect_out("R5 wrap to head", 1, 1, 0, 1, 16'h50);
        send(16'h77);
        expect_out("R7 miss", 0, 0, 1, 0, '0);
        send(16'h77);
        expect_out("R8 close length 1", 1, 0, 0, 1, 16'h77);
        send(16'h77);
        expect_out("R5 length 1 hit", 1, 1, 0, 1, 16'h77);
    endtask

    // R9 and R8: overflow by one, then a cycle filling the ring exactly
    task automatic t_overflow();
        send(16'h100);
        expect_out("R7 miss", 0, 0, 1, 0, '0);
        for (int k = 1; k <= 31; k++) begin
            send(16'h100 + 16'(k));
        end
        expect_out("R8 quiet after 32 entries", 0, 0, 0, 0, '0);
        send(16'h200);
        expect_out("R9 overflow new head", 0, 0, 0, 0, '0);
        send(16'h100);
        expect_out("R9 old head no longer closes", 0, 0, 0, 0, '0);
        send(16'h200);
        expect_out("R9 close on new head", 1, 0, 0, 1, 16'h100);
        send(16'h400);
        expect_out("R7 miss", 0, 0, 1, 0, '0);
        for (int k = 1; k <= 31; k++) begin
            send(16'h400 + 16'(k));
        end
        send(16'h400);
        expect_out("R8 close at length 32", 1, 0, 0, 1, 16'h401);
        send(16'h401);
        expect_out("R5 hit in full ring", 1, 1, 0, 1, 16'h402);
    endtask

    // R10 then R3: reset mid-run; a length-3 and length-2 recurrence ignored
    task automatic t_short_ignored();
        do_reset();
        expect_out("R10 reset leaves prediction", 0, 0, 0, 0, '0);
        send(16'h5); send(16'h6); send(16'h7); send(16'h5);
        expect_out("R10 length 3 ignored after reset", 0, 0, 0, 0, '0);
        do_reset();
        for (int k = 0; k < 10; k++) begin
            send(16'h11);
            send(16'h22);
            expect_out("R3 length 2 ignored", 0, 0, 0, 0, '0);
        end
        for (int k = 0; k < 6; k++) begin
            send(16'h31 + 16'(k));
            expect_out("R3 still initializing", 0, 0, 0, 0, '0);
        end
        send(16'h31);
        expect_out("R3 length 6 closes", 1, 0, 0, 1, 16'h32);
    endtask

    // R4: nine distinct heads evict the first; later recurrence of third closes
    task automatic t_replace();
        do_reset();
        for (int k = 1; k <= 9; k++) begin
            send(16'hA0 + 16'(k));
        end
        send(16'hA1);
        expect_out("R4 evicted head does not close", 0, 0, 0, 0, '0);
        send(16'hA3);
        expect_out("R4 surviving head closes", 1, 0, 0, 1, 16'hA4);
        for (int k = 4; k <= 9; k++) begin
            send(16'hA0 + 16'(k));
        end
        expect_out("R4 cycle ends with evicted id", 1, 1, 0, 1, 16'hA1);
    endtask

    initial begin
        t_init_close();
        t_miss_reform();
        t_overflow();
        t_short_ignored();
        t_replace();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule